// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and an external asynchronous 256K x 8 static RAM. The host issues one read or write at a time over a valid/ready request channel. The controller then produces the active-low chip select, write strobe and output enable for the RAM, and holds the 18-bit address steady for the whole access. It controls the 8-bit data bus through a separate output word and driver enable, so the pad ring or the testbench resolves the shared bus.

Each strobe phase lasts a whole number of system clock cycles. That number comes from the nanosecond limits of the chosen speed grade, divided by the clock period and rounded up, with a floor of one cycle. A read holds select and output enable low for the full access window. The controller captures the data bus on the last cycle of that window and returns it with a one-cycle response pulse. A write opens the strobe with the data drivers already on and output enable high. It then keeps select low and the data driven through a recovery phase that also stretches the access to the full write cycle time. When no access is running, every strobe is high and the drivers are off, which puts a low-power RAM in standby.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset and whenever req_ready is high, ram_cs_n, ram_we_n and ram_oe_n are 1 and ram_dq_oe is 0.
- R2: A read holds ram_cs_n and ram_oe_n at 0 and ram_we_n at 1 for exactly RD cycles, where RD = max(1, ceil(grade access time / CLK_NS)). The access times are 55, 70, 85, 100 and 120 ns for GRADE 0 to 4. ram_addr stays constant while ram_cs_n is 0.
- R3: rsp_valid is high for exactly one cycle, RD+1 clock edges after the accepting edge. rsp_rdata then holds the bus value seen on the last read cycle.
- R4: A write holds ram_we_n at 0 for exactly WP cycles, with ram_cs_n at 0, ram_oe_n at 1, ram_dq_oe at 1 and ram_dq_out stable. WP = max(1, ceil(max(pulse, data setup) / CLK_NS)), with pulse 40/50/65/75/85 ns and data setup 25/30/35/40/45 ns for GRADE 0 to 4.
- R5: After ram_we_n rises, ram_cs_n stays 0 and the data stays driven for exactly REC cycles. REC = max(1, ceil(recovery / CLK_NS), ceil(cycle / CLK_NS) - WP), with recovery 0/0/5/5/10 ns and cycle 55/70/85/100/120 ns.
- R6: At least one cycle with ram_oe_n at 1 and ram_dq_oe at 0 separates a cycle with ram_oe_n at 0 from any cycle with ram_dq_oe at 1.
- R7: ram_dq_oe at 1 implies ram_oe_n at 1, so the controller and the RAM never drive the bus together.
- R8: While an access is running, req_ready is 0 and a pending request is not started. rsp_valid pulses once per read and never for a write.
- R9: ram_we_n is 0 only while ram_cs_n is 0, and ram_we_n stays 1 throughout a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 8 | Read data |
| ram_addr | output | 18 | RAM address lines |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | 8 | Data the controller drives on the bus |
| ram_dq_oe | output | 1 | Controller data driver enable |
| ram_dq_in | input | 8 | Data sampled from the bus |

## Verification
The assertions check, on every cycle, the relations between strobes that must always hold. These are the idle strobe state, no overlap of the driver enable with output enable, a write strobe only inside select, a stable address and write word, a single-cycle response and the read-to-write gap. The exact phase lengths in cycles, the response latency and the data returned can only be seen in bench scenarios. There, a RAM model delivers valid data only after the access time, and the bench measures each phase and compares reads against a shadow of the writes. Back-to-back pairs, with a write held pending behind a busy access and a write issued in the response cycle of a read, show R6 and R8 in action.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int unsigned SRAM_AW = 18;
    localparam int unsigned SRAM_DW = 8;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_READ    = 2'd1,
        PH_WSTROBE = 2'd2,
        PH_WRECOV  = 2'd3
    } phase_e;

    typedef struct packed {
        logic               write;
        logic [SRAM_AW-1:0] addr;
        logic [SRAM_DW-1:0] data;
    } sram_req_t;

    typedef struct packed {
        logic               cs_n;
        logic               we_n;
        logic               oe_n;
        logic               dq_oe;
    } sram_strobe_t;

    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned imax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Full cycle / access time per speed grade index
    function automatic int unsigned grade_cycle_ns(int unsigned g);
        case (g)
            0: return 55;
            1: return 70;
            2: return 85;
            3: return 100;
            default: return 120;
        endcase
    endfunction

    function automatic int unsigned grade_oe_ns(int unsigned g);
        case (g)
            0: return 30;
            1: return 35;
            2: return 55;
            3: return 60;
            default: return 70;
        endcase
    endfunction

    function automatic int unsigned grade_wp_ns(int unsigned g);
        case (g)
            0: return 40;
            1: return 50;
            2: return 65;
            3: return 75;
            default: return 85;
        endcase
    endfunction

    function automatic int unsigned grade_dsu_ns(int unsigned g);
        case (g)
            0: return 25;
            1: return 30;
            2: return 35;
            3: return 40;
            default: return 45;
        endcase
    endfunction

    function automatic int unsigned grade_wrec_ns(int unsigned g);
        case (g)
            0, 1: return 0;
            2, 3: return 5;
            default: return 10;
        endcase
    endfunction

    function automatic int unsigned rd_cycles(int unsigned g, int unsigned clk_ns);
        return ns_to_cyc(imax(grade_cycle_ns(g), grade_oe_ns(g)), clk_ns);
    endfunction

    function automatic int unsigned wp_cycles(int unsigned g, int unsigned clk_ns);
        return ns_to_cyc(imax(grade_wp_ns(g), grade_dsu_ns(g)), clk_ns);
    endfunction

    function automatic int unsigned rec_cycles(int unsigned g, int unsigned clk_ns);
        int unsigned wc;
        int unsigned wp;
        int unsigned fill;
        wc   = ns_to_cyc(grade_cycle_ns(g), clk_ns);
        wp   = wp_cycles(g, clk_ns);
        fill = (wc > wp) ? (wc - wp) : 0;
        return imax(imax(ns_to_cyc(grade_wrec_ns(g), clk_ns), fill), 1);
    endfunction

endpackage

// File: rtl/sram_req_latch.sv
module sram_req_latch
    import sram_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  sram_req_t req_in,
    output sram_req_t req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (take) begin
            req_q <= req_in;
        end
    end
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned RD_N  = 6,
    parameter int unsigned WP_N  = 4,
    parameter int unsigned REC_N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         start_write,
    output phase_e       phase,
    output logic         read_last,
    output sram_strobe_t strobe
);
    localparam int unsigned MAX_N = imax(imax(RD_N, WP_N), REC_N);
    localparam int unsigned CW    = (MAX_N > 1) ? $clog2(MAX_N) : 1;
    localparam logic [CW-1:0] RD_LOAD  = CW'(RD_N - 1);
    localparam logic [CW-1:0] WP_LOAD  = CW'(WP_N - 1);
    localparam logic [CW-1:0] REC_LOAD = CW'(REC_N - 1);

    phase_e        ph_q, ph_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_zero ? cnt_q : cnt_q - 1'b1;
        unique case (ph_q)
            PH_IDLE: begin
                if (start) begin
                    ph_d  = start_write ? PH_WSTROBE : PH_READ;
                    cnt_d = start_write ? WP_LOAD : RD_LOAD;
                end
            end
            PH_READ: begin
                if (cnt_zero) ph_d = PH_IDLE;
            end
            PH_WSTROBE: begin
                if (cnt_zero) begin
                    ph_d  = PH_WRECOV;
                    cnt_d = REC_LOAD;
                end
            end
            PH_WRECOV: begin
                if (cnt_zero) ph_d = PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        strobe = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        unique case (ph_q)
            PH_READ:    strobe = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            PH_WSTROBE: strobe = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            PH_WRECOV:  strobe = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            default:    strobe = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        endcase
    end

    assign phase     = ph_q;
    assign read_last = (ph_q == PH_READ) && cnt_zero;
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture
    import sram_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               grab,
    input  logic [SRAM_DW-1:0] bus_in,
    output logic               rsp_valid,
    output logic [SRAM_DW-1:0] rsp_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= grab;
            if (grab) rsp_data <= bus_in;
        end
    end
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned GRADE  = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [SRAM_AW-1:0] req_addr,
    input  logic [SRAM_DW-1:0] req_wdata,
    output logic               rsp_valid,
    output logic [SRAM_DW-1:0] rsp_rdata,
    output logic [SRAM_AW-1:0] ram_addr,
    output logic               ram_cs_n,
    output logic               ram_we_n,
    output logic               ram_oe_n,
    output logic [SRAM_DW-1:0] ram_dq_out,
    output logic               ram_dq_oe,
    input  logic [SRAM_DW-1:0] ram_dq_in
);
    localparam int unsigned RD_N  = rd_cycles(GRADE, CLK_NS);
    localparam int unsigned WP_N  = wp_cycles(GRADE, CLK_NS);
    localparam int unsigned REC_N = rec_cycles(GRADE, CLK_NS);

    phase_e       phase;
    logic         read_last;
    logic         accept;
    sram_strobe_t strobe;
    sram_req_t    req_in, req_q;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign req_in    = '{write: req_write, addr: req_addr, data: req_wdata};

    sram_req_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .take   (accept),
        .req_in (req_in),
        .req_q  (req_q)
    );

    sram_phase_seq #(
        .RD_N  (RD_N),
        .WP_N  (WP_N),
        .REC_N (REC_N)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_write (req_write),
        .phase       (phase),
        .read_last   (read_last),
        .strobe      (strobe)
    );

    sram_rd_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .grab      (read_last),
        .bus_in    (ram_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_rdata)
    );

    assign ram_addr   = req_q.addr;
    assign ram_dq_out = req_q.data;
    assign ram_cs_n   = strobe.cs_n;
    assign ram_we_n   = strobe.we_n;
    assign ram_oe_n   = strobe.oe_n;
    assign ram_dq_oe  = strobe.dq_oe;
endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk
    import sram_ctl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               ram_cs_n,
    input logic               ram_we_n,
    input logic               ram_oe_n,
    input logic               ram_dq_oe,
    input logic [SRAM_AW-1:0] ram_addr,
    input logic [SRAM_DW-1:0] ram_dq_out
);
    AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe)); // R1

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr)); // R2

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R3

    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out)); // R4

    AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |=> !ram_dq_oe); // R6

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |-> ram_oe_n); // R7

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !ram_cs_n |-> !req_ready); // R8

    AST_WE_IN_SELECT: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (!ram_cs_n && ram_oe_n && ram_dq_oe)); // R9
endmodule

bind sram_async_ctl sram_async_ctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .ram_cs_n   (ram_cs_n),
    .ram_we_n   (ram_we_n),
    .ram_oe_n   (ram_oe_n),
    .ram_dq_oe  (ram_dq_oe),
    .ram_addr   (ram_addr),
    .ram_dq_out (ram_dq_out)
);

// File: tb/tb_sram_async_ctl.sv
`timescale 1ns/1ps
module tb_sram_async_ctl;
    localparam int CLK_NS = 10;
    localparam int GRADE  = 0;

    // Bench-side timing expectations from the requirement text
    function automatic int up(int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int tbl(int kind);
        int t [5][5] = '{'{55, 70, 85, 100, 120},
                         '{40, 50, 65, 75, 85},
                         '{25, 30, 35, 40, 45},
                         '{0, 0, 5, 5, 10},
                         '{30, 35, 55, 60, 70}};
        return t[kind][GRADE];
    endfunction
    function automatic int exp_rd();
        return up(tbl(0));
    endfunction
    function automatic int exp_wp();
        return up((tbl(1) > tbl(2)) ? tbl(1) : tbl(2));
    endfunction
    function automatic int exp_rec();
        int r;
        int f;
        r = up(tbl(3));
        f = up(tbl(0)) - exp_wp();
        if (f > r) r = f;
        return (r < 1) ? 1 : r;
    endfunction
    function automatic logic [7:0] init_val(logic [17:0] a);
        return a[7:0] ^ a[17:10] ^ 8'h3C;
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [17:0] ram_addr;
    logic        ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [7:0]  ram_dq_out;
    wire  [7:0]  bus;

    always #5 clk = ~clk;

    sram_async_ctl #(.CLK_NS(CLK_NS), .GRADE(GRADE)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(bus)
    );

    // Behavioural RAM: valid data only after the access time
    logic [7:0] mem [logic [17:0]];
    logic       rd_ok = 1'b0;
    logic       ram_drv;
    logic [7:0] ram_q;
    assign ram_drv = (ram_cs_n === 1'b0) && (ram_oe_n === 1'b0) && (ram_we_n === 1'b1);
    assign ram_q   = !rd_ok ? 8'hEE : (mem.exists(ram_addr) ? mem[ram_addr] : init_val(ram_addr));
    assign bus     = ram_dq_oe ? ram_dq_out : (ram_drv ? ram_q : 8'hzz);

    always @(negedge ram_oe_n) begin
        rd_ok = 1'b0;
        #(tbl(0));
        if (ram_oe_n === 1'b0) rd_ok = 1'b1;
    end
    always @(posedge ram_oe_n) rd_ok = 1'b0;
    always @(posedge ram_we_n) if (ram_cs_n === 1'b0) mem[ram_addr] = bus;

    int n_chk = 0;
    int n_fail = 0;
    int n_reads = 0;
    int n_rsp = 0;
    logic [7:0] shadow [logic [17:0]];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Phase-length and bus monitors
    int  rd_run = 0, we_run = 0, rec_run = 0;
    bit  prev_oe_low = 1'b0, prev_dq_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!ram_cs_n && !ram_oe_n) begin
                rd_run++;
                if (ram_we_n !== 1'b1) chk(0, "R9 we during read", ram_we_n, 1);
            end else if (rd_run > 0) begin
                chk(rd_run == exp_rd(), "R2 read window", rd_run, exp_rd());
                rd_run = 0;
            end
            if (!ram_we_n) we_run++;
            else if (we_run > 0) begin
                chk(we_run == exp_wp(), "R4 write strobe", we_run, exp_wp());
                we_run = 0;
            end
            if (!ram_cs_n && ram_we_n && ram_oe_n) rec_run++;
            else if (rec_run > 0) begin
                chk(rec_run == exp_rec(), "R5 write recovery", rec_run, exp_rec());
                rec_run = 0;
            end
            if (ram_dq_oe && !prev_dq_oe)
                chk(!prev_oe_low, "R6 turnaround gap", prev_oe_low, 0);
            if (ram_dq_oe && ram_drv) chk(0, "R7 bus contention", 1, 0);
            if (rsp_valid) n_rsp++;
            prev_oe_low = !ram_oe_n;
            prev_dq_oe  = ram_dq_oe;
        end
    end

    // Called at a negedge; a write returns right after acceptance,
    // a read returns at the negedge where the response is seen.
    task automatic do_req(input bit w, input logic [17:0] a, input logic [7:0] d);
        int lat;
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        if (w) begin
            shadow[a] = d;
            @(negedge clk);
        end else begin
            n_reads++;
            lat = 0;
            do begin
                @(negedge clk);
                lat++;
            end while (!rsp_valid && lat < 500);
            chk(lat == exp_rd() + 1, "R3 response latency", lat, exp_rd() + 1);
            chk(rsp_rdata == (shadow.exists(a) ? shadow[a] : init_val(a)),
                "R3 read data", rsp_rdata, shadow.exists(a) ? shadow[a] : init_val(a));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd7);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && req_ready,
            "R1 idle strobes", {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, req_ready}, 5'b11101);
        // Directed: address extremes
        do_req(1'b1, 18'h00000, 8'h5A);
        do_req(1'b1, 18'h3FFFF, 8'hA5);
        do_req(1'b0, 18'h00000, 8'h00);
        do_req(1'b0, 18'h3FFFF, 8'h00);
        do_req(1'b0, 18'h12345, 8'h00);      // never written
        // R6: write issued in the response cycle of a read
        do_req(1'b0, 18'h3FFFF, 8'h00);
        do_req(1'b1, 18'h00011, 8'hC3);
        // R8: write pending behind a busy write, then read back
        do_req(1'b1, 18'h00012, 8'h3C);
        do_req(1'b0, 18'h00011, 8'h00);
        do_req(1'b0, 18'h00012, 8'h00);
        chk(req_ready && ram_cs_n, "R1 idle after access", req_ready, 1);
        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [17:0] a;
            r = $urandom;
            a = (r[3:0] == 4'd0) ? 18'h3FFFF : (18'h2_0400 + 18'(r[9:7]));
            do_req(r[12], a, r[27:20]);
            if (r[15:14] == 2'b00) repeat (r[17:16]) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        chk(n_rsp == n_reads, "R8 one response per read", n_rsp, n_reads);
        chk(ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe, "R1 standby at end",
            {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe}, 4'b1110);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule